// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Address Pointer

This block is the slave side of a two-wire serial EEPROM holding 2048 bytes in an internal register array. It watches the clock and data lines, finds start and stop conditions, and decodes the device-address byte. That byte carries a fixed 4-bit device-type code, three page-select bits and a read/write flag. The block then serves byte writes, page writes, current-address reads and sequential reads. Its only output is an enable that pulls the open-drain data line low.

The memory address is 11 bits wide. The three page-select bits are the upper part and an 8-bit word address is the lower part. A single pointer is kept across transactions, and reads and writes advance it under different rules. Writes roll over inside a 16-byte page. Reads step the whole address.

Top module: `eeprom_slave`

## Requirements
- R1: A device-address byte whose upper four bits are 1010 is acknowledged by pulling the data line low during the ninth clock. Any other code gets no acknowledge, and the rest of the transaction is ignored with the data line left released.
- R2: With the read/write bit (bit 0 of the device-address byte) at 0, the next byte is a word address, and it is acknowledged. The pointer becomes {device-address bits 3:1, word address}.
- R3: Each data byte after the word address is acknowledged and stored at the pointer.
- R4: After each stored data byte, only the low 4 pointer bits increment, wrapping inside the 16-byte page. The upper 7 bits stay as they were.
- R5: With the read/write bit at 1, the page bits of the device-address byte are ignored and the read starts at the held pointer.
- R6: Read data is sent most significant bit first, one bit per clock.
- R7: After each byte read, the full 11-bit pointer increments at the falling clock edge of the eighth data bit. It crosses page boundaries and wraps from 0x7FF to 0x000.
- R8: When the master acknowledges a read byte, the byte at the next address follows. A missing acknowledge ends the read, and the data line stays released.
- R9: The pointer keeps its value across stop conditions.
- R10: A start or stop condition aborts any transfer in progress, with no partial byte stored. A repeated start begins a new device-address byte.
- R11: The pull-down enable changes only while the clock line is low.
- R12: Reset releases the data line and clears the pointer to 0. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired-AND of master and slave) |
| sdaPullDown | output | 1 | When high, the data line is pulled low |

## Verification
The bench uses the default parameters: an 11-bit address, 4-bit page offset and device code 1010. With these values, the top address 0x7FF and the pointer's wrap to zero are reached in one short transaction, and so is a page crossing from 0x2FF to 0x300. A three-byte page write starting at offset 0xE shows the low-bit rollover, and a read through a device address carrying other page bits shows that those bits are ignored. Partial bytes cut short by a stop, and a repeated start placed after a word address, exercise the abort paths.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } ctlState_t;

  // strobes from control to datapath, at most a few per cycle
  typedef struct packed {
    logic shiftIn;    // sample one received bit
    logic latchPage;  // capture page-select bits of a write device address
    logic loadPtr;    // pointer <= {page, word}
    logic writeMem;   // store received byte at pointer
    logic stepPage;   // low-bit increment inside a page
    logic stepFull;   // full-width increment
    logic loadTx;     // fetch byte at pointer for sending
    logic shiftTx;    // advance transmit shifter
    logic abort;      // start/stop seen: drop partial bytes
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdaSync,
  input  dpStrobe_t         strb,
  output logic              devMatch,
  output logic              rwBit,
  output logic              headBit,
  output logic              nextTxBit,
  output logic [ADDR_W-1:0] ptr
);

  localparam int SEL_W = ADDR_W - 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [7:0]        rxShift;
  logic [SEL_W-1:0]  pageSel;
  logic [ADDR_W-1:0] ptrQ;
  logic [6:0]        txShift;
  logic [7:0]        mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShift <= '0;
      pageSel <= '0;
      ptrQ    <= '0;
      txShift <= '0;
    end else begin
      if (strb.abort)
        rxShift <= '0;
      else if (strb.shiftIn)
        rxShift <= {rxShift[6:0], sdaSync};

      if (strb.latchPage)
        pageSel <= rxShift[SEL_W:1];

      if (strb.loadPtr)
        ptrQ <= {pageSel, rxShift};
      else if (strb.stepPage)
        ptrQ <= {ptrQ[ADDR_W-1:PAGE_W], ptrQ[PAGE_W-1:0] + PAGE_ONE};
      else if (strb.stepFull)
        ptrQ <= ptrQ + ADDR_ONE;

      if (strb.abort)
        txShift <= '0;
      else if (strb.loadTx)
        txShift <= mem[ptrQ][6:0];
      else if (strb.shiftTx)
        txShift <= {txShift[5:0], 1'b0};
    end
  end

  // storage array carries no reset so contents survive rst_n
  always_ff @(posedge clk) begin
    if (strb.writeMem)
      mem[ptrQ] <= rxShift;
  end

  assign devMatch  = (rxShift[7:4] == DEV_CODE);
  assign rwBit     = rxShift[0];
  assign headBit   = mem[ptrQ][7];
  assign nextTxBit = txShift[6];
  assign ptr       = ptrQ;

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      devMatch,
  input  logic      rwBit,
  input  logic      headBit,
  input  logic      nextTxBit,
  output dpStrobe_t strb,
  output logic      sdaSync,
  output logic      sdaPullDown
);

  logic sclQ, sclP, sdaQ, sdaP;
  logic sclRise, sclFall, startEv, stopEv;

  ctlState_t state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic isRead, isReadN;
  logic masterAck, masterAckN;
  logic drive, driveN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclQ <= 1'b1;
      sclP <= 1'b1;
      sdaQ <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sclP <= sclQ;
      sdaQ <= sdaIn;
      sdaP <= sdaQ;
    end
  end

  assign sclRise = sclQ & ~sclP;
  assign sclFall = ~sclQ & sclP;
  assign startEv = sclQ & sclP & sdaP & ~sdaQ;
  assign stopEv  = sclQ & sclP & ~sdaP & sdaQ;

  always_comb begin
    stateN     = state;
    bitCntN    = bitCnt;
    isReadN    = isRead;
    masterAckN = masterAck;
    driveN     = drive;
    strb       = '0;

    if (startEv) begin
      stateN     = ST_DEV;
      bitCntN    = 4'd0;
      driveN     = 1'b0;
      strb.abort = 1'b1;
    end else if (stopEv) begin
      stateN     = ST_IDLE;
      bitCntN    = 4'd0;
      driveN     = 1'b0;
      strb.abort = 1'b1;
    end else if (sclRise) begin
      case (state)
        ST_DEV, ST_WORD, ST_WDATA: begin
          strb.shiftIn = 1'b1;
          bitCntN      = bitCnt + 4'd1;
        end
        ST_RDATA:     bitCntN    = bitCnt + 4'd1;
        ST_RDATA_ACK: masterAckN = ~sdaQ;
        default: ;
      endcase
    end else if (sclFall) begin
      case (state)
        ST_DEV: begin
          if (bitCnt == 4'd8) begin
            if (devMatch) begin
              stateN         = ST_DEV_ACK;
              driveN         = 1'b1;
              isReadN        = rwBit;
              strb.latchPage = ~rwBit;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_DEV_ACK: begin
          bitCntN = 4'd0;
          if (isRead) begin
            stateN      = ST_RDATA;
            strb.loadTx = 1'b1;
            driveN      = ~headBit;
          end else begin
            stateN = ST_WORD;
            driveN = 1'b0;
          end
        end
        ST_WORD: begin
          if (bitCnt == 4'd8) begin
            strb.loadPtr = 1'b1;
            stateN       = ST_WORD_ACK;
            driveN       = 1'b1;
          end
        end
        ST_WORD_ACK, ST_WDATA_ACK: begin
          stateN  = ST_WDATA;
          bitCntN = 4'd0;
          driveN  = 1'b0;
        end
        ST_WDATA: begin
          if (bitCnt == 4'd8) begin
            strb.writeMem = 1'b1;
            strb.stepPage = 1'b1;
            stateN        = ST_WDATA_ACK;
            driveN        = 1'b1;
          end
        end
        ST_RDATA: begin
          if (bitCnt == 4'd8) begin
            strb.stepFull = 1'b1;
            stateN        = ST_RDATA_ACK;
            driveN        = 1'b0;
          end else begin
            strb.shiftTx = 1'b1;
            driveN       = ~nextTxBit;
          end
        end
        ST_RDATA_ACK: begin
          if (masterAck) begin
            stateN      = ST_RDATA;
            bitCntN     = 4'd0;
            strb.loadTx = 1'b1;
            driveN      = ~headBit;
          end else begin
            stateN = ST_IDLE;
            driveN = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitCnt    <= 4'd0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      drive     <= 1'b0;
    end else begin
      state     <= stateN;
      bitCnt    <= bitCntN;
      isRead    <= isReadN;
      masterAck <= masterAckN;
      drive     <= driveN;
    end
  end

  assign sdaSync     = sdaQ;
  assign sdaPullDown = drive;

endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullDown
);

  dpStrobe_t         strb;
  logic              sdaSync;
  logic              devMatch;
  logic              rwBit;
  logic              headBit;
  logic              nextTxBit;
  logic [ADDR_W-1:0] ptr;

  eeprom_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .devMatch    (devMatch),
    .rwBit       (rwBit),
    .headBit     (headBit),
    .nextTxBit   (nextTxBit),
    .strb        (strb),
    .sdaSync     (sdaSync),
    .sdaPullDown (sdaPullDown)
  );

  eeprom_dp #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .DEV_CODE (DEV_CODE)
  ) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdaSync   (sdaSync),
    .strb      (strb),
    .devMatch  (devMatch),
    .rwBit     (rwBit),
    .headBit   (headBit),
    .nextTxBit (nextTxBit),
    .ptr       (ptr)
  );

endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclIn,
  input logic              sdaPullDown,
  input dpStrobe_t         strb,
  input logic [ADDR_W-1:0] ptr
);

  // R11: the data line enable moves only during clock-low
  assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaPullDown) |-> !sclIn);

  // R4: a write step keeps the upper bits and bumps the low field
  assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.stepPage |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) &&
                      (ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1)));

  // R7: a read step advances the whole pointer
  assert_full_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.stepFull |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  // R9: pointer holds when no update strobe is raised
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.loadPtr | strb.stepPage | strb.stepFull) |=> $stable(ptr));

  // R10: start or stop releases the line on the next cycle
  assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.abort |=> !sdaPullDown);

  // R3: at most one byte-level transfer action per cycle
  assert_single_action_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.shiftIn, strb.latchPage, strb.loadPtr, strb.writeMem,
              strb.loadTx, strb.shiftTx}));

endmodule

bind eeprom_slave eeprom_slave_chk #(
  .ADDR_W (ADDR_W),
  .PAGE_W (PAGE_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclIn       (sclIn),
  .sdaPullDown (sdaPullDown),
  .strb        (strb),
  .ptr         (ptr)
);

// File: tb/test_eeprom_slave.sv
module test_eeprom_slave;

  localparam int Q = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaPullDown;
  logic sdaLine;
  assign sdaLine = mSda & ~sdaPullDown;

  eeprom_slave i_eeprom_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclIn       (mScl),
    .sdaIn       (sdaLine),
    .sdaPullDown (sdaPullDown)
  );

  int checks = 0;
  int fails  = 0;
  int r11Bad = 0;
  bit done   = 0;

  logic [7:0] refMem [int];
  int refPtr = 0;

  logic [7:0] expQ [$];
  string      tagQ [$];
  logic [7:0] gotQ [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read bytes arrive
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0 && expQ.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = gotQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(g == e, t, "read byte", g, e);
      end
    end
  end

  // R11 watcher: line enable must not move with the clock high
  logic prevPd = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst_n && sdaPullDown != prevPd && mScl) r11Bad++;
    prevPd = sdaPullDown;
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startBit();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic stopBit();
    mScl = 1'b0; mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic putBit(input logic b);
    mSda = b; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic putByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    acked = !sdaLine;
    waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic getByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      mScl = 1'b1; waitQ();
      b[i] = sdaLine;
      waitQ();
      mScl = 1'b0;
    end
    waitQ();
    mSda = !giveAck; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
    mSda = 1'b1;
  endtask

  function automatic int pageStep(input int p);
    return (p & 32'h7F0) | ((p + 1) & 32'hF);
  endfunction

  task automatic writeSeq(input logic [7:0] dev, input logic [7:0] word, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    bit a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    startBit();
    putByte(dev, a);
    check(a, "R1", "device address ack", a, 1);
    putByte(word, a);
    check(a, "R2", "word address ack", a, 1);
    refPtr = {21'd0, dev[3:1], word};
    for (int k = 0; k < n; k++) begin
      putByte(d[k], a);
      check(a, "R3", "data ack", a, 1);
      refMem[refPtr] = d[k];
      refPtr = pageStep(refPtr);
    end
    stopBit();
  endtask

  task automatic readSeq(input logic [7:0] dev, input int n, input string tag);
    bit a;
    logic [7:0] b;
    startBit();
    putByte(dev, a);
    check(a, "R1", "read device address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      expQ.push_back(refMem[refPtr]);
      tagQ.push_back(tag);
      getByte(k < n - 1, b);
      gotQ.push_back(b);
      refPtr = (refPtr + 1) & 32'h7FF;
    end
    stopBit();
    check(sdaPullDown == 1'b0 && sdaLine == 1'b1, "R8", "line released after no-ack",
          sdaPullDown, 0);
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    refPtr = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    bit a;
    doReset();
    check(sdaPullDown == 1'b0, "R12", "line released after reset", sdaPullDown, 0);

    writeSeq(8'hA0, 8'h00, 1, 8'h5A, 8'h00, 8'h00);
    writeSeq(8'hA0, 8'h40, 1, 8'h3C, 8'h00, 8'h00);
    writeSeq(8'hA6, 8'h00, 1, 8'h77, 8'h00, 8'h00);
    writeSeq(8'hA2, 8'h23, 1, 8'h11, 8'h00, 8'h00);

    // R12: reset clears pointer, memory kept
    doReset();
    readSeq(8'hA1, 1, "R12");

    // R1: foreign device code is not acknowledged and nothing follows
    startBit();
    putByte(8'hB0, a);
    check(!a, "R1", "foreign code no ack", a, 0);
    putByte(8'h00, a);
    check(!a, "R1", "ignored byte no ack", a, 0);
    stopBit();

    // R4: page write from offset 0xE rolls to 0x0 in the same page
    writeSeq(8'hA4, 8'hFE, 3, 8'h31, 8'h32, 8'h33);
    check(refPtr == 32'h2F1, "R4", "model pointer", refPtr, 32'h2F1);
    writeSeq(8'hA4, 8'hF0, 0, 8'h00, 8'h00, 8'h00);
    readSeq(8'hAF, 1, "R4");

    // R5/R6/R7/R8/R9: pointer set, stop, read with other page bits, page crossing
    writeSeq(8'hA4, 8'hFE, 0, 8'h00, 8'h00, 8'h00);
    readSeq(8'hAF, 3, "R5 R6 R7 R8 R9");

    // R7: wrap from the top address to zero
    writeSeq(8'hAE, 8'hFF, 1, 8'h99, 8'h00, 8'h00);
    writeSeq(8'hAE, 8'hFF, 0, 8'h00, 8'h00, 8'h00);
    readSeq(8'hA1, 2, "R7");

    // R10: stop in the middle of a data byte stores nothing
    startBit();
    putByte(8'hA0, a);
    putByte(8'h40, a);
    refPtr = 32'h040;
    for (int i = 0; i < 4; i++) putBit(1'b1);
    stopBit();
    readSeq(8'hA1, 1, "R10");

    // R10: repeated start after word address begins a read there
    startBit();
    putByte(8'hA0, a);
    putByte(8'h00, a);
    refPtr = 0;
    readSeq(8'hA1, 1, "R10");

    repeat (20) @(negedge clk);
    check(expQ.size() == 0 && gotQ.size() == 0, "R6", "scoreboard drained",
          expQ.size(), 0);
    check(r11Bad == 0, "R11", "line moves with clock high", r11Bad, 0);
    done = 1;
    finishRun();
  end

endmodule